// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends 8-bit frames over a clocked synchronous serial link. A host writes a byte into a holding register. The write clears a "holding empty" flag. The block then copies the byte into a shift register, sets the empty flag again so the host can supply the next byte, and shifts the byte out least significant bit first. The next byte is therefore written while the current one is still on the wire.

In internal-clock mode the block makes the serial clock itself from a programmable half-period divider of the system clock. Each frame gets eight low/high clock pulses. Data changes on the falling edge so that a receiver can sample on the rising edge. In external-clock mode the serial clock output stays high, and the block steps its data on the falling edges of an incoming clock, after synchronising that clock.

When a frame closes, the block looks for a new byte. If one is waiting, the next frame starts with no idle time. If none is waiting, the block raises a transmit-end flag, parks the data line at the level of the last bit and parks the clock high. Two level interrupt requests, each with its own enable, follow the empty flag and the transmit-end flag.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, `empty_flag`=1, `end_flag`=1, `sclk_out`=1 and `sdata`=1, and both interrupt outputs follow their enables.
- R2: A cycle with `wr_en`=1 stores `wr_data` and clears both `empty_flag` and `end_flag` at the next clock edge.
- R3: When the block is idle and `empty_flag` is 0, the next edge copies the stored byte into the shifter and sets `empty_flag` to 1. In internal mode the same edge drives `sclk_out` low and puts bit 0 on `sdata`.
- R4: In internal mode a frame is eight pulses of `sclk_out`. Each low half and each high half lasts `half_period` system cycles, and a value of 0 counts as 1. Bits go out in the order bit 0 to bit 7. `sdata` changes only when `sclk_out` falls.
- R5: If `empty_flag` is 0 when the high half of bit 7 ends, the next frame's bit 0 follows at once. The rising edges of `sclk_out` stay exactly 2×`half_period` cycles apart across the frame boundary, and `end_flag` stays 0.
- R6: If `empty_flag` is 1 when bit 7 closes, `end_flag` goes to 1, `sdata` keeps the bit-7 value and `sclk_out` rests high until the next load.
- R7: `empty_irq` is 1 exactly when both `empty_flag` and `empty_ie` are 1. `end_irq` is 1 exactly when both `end_flag` and `end_ie` are 1. Both are levels.
- R8: With `ext_clk_sel`=1, `sclk_out` stays high. Bit 0 is presented at load. Each falling edge of `sclk_in` that follows a rising edge moves to the next bit. The eighth rising edge closes the frame. `sclk_in` passes through a two-stage synchroniser.
- R9: A write in the same cycle as a load leaves `empty_flag` at 0, and both bytes go out in order. A write in the cycle where a frame closes with nothing waiting keeps `end_flag` at 0, and the byte goes out next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| empty_ie | input | 1 | Enable for the empty interrupt request |
| end_ie | input | 1 | Enable for the transmit-end interrupt request |
| ext_clk_sel | input | 1 | 1 selects the external serial clock |
| sclk_in | input | 1 | External serial clock |
| half_period | input | 8 | Internal clock half period in system cycles |
| sclk_out | output | 1 | Serial clock output |
| sdata | output | 1 | Serial data output |
| empty_flag | output | 1 | Holding register free for a new byte |
| end_flag | output | 1 | Transmission ended with no byte waiting |
| empty_irq | output | 1 | Empty interrupt request |
| end_irq | output | 1 | Transmit-end interrupt request |

## Verification
Two host writes can land in the same edges as the shifter's own actions. One lands on the load edge, where the shifter sets the empty flag while the write clears it. The other lands on the frame-close edge, where the shifter sets the transmit-end flag while the write clears it. The bench provokes the first with writes on two consecutive cycles from idle. It provokes the second by writing on the cycle right after it sees the eighth rising clock edge of a frame at the shortest half period. It judges both by the flag values on the following cycle and by the serial bytes a bench-side receiver collects on the rising edges of `sclk_out`.

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              empty_ie,
  input  logic              end_ie,
  input  logic              ext_clk_sel,
  input  logic              sclk_in,
  input  logic [DIV_W-1:0]  half_period,
  output logic              sclk_out,
  output logic              sdata,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              empty_irq,
  output logic              end_irq
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] hold_q, shift_q;
  logic              empty_q, end_q, busy, phase_hi, armed, sclk_q, sdata_q;
  logic [BIT_W-1:0]  bitn;
  logic [DIV_W-1:0]  cnt;
  logic [2:0]        sync_q;

  logic [DIV_W-1:0] half_m1;
  logic             tick, ext_rise, ext_fall, frame_end, load;
  logic [BIT_W-1:0] nxt_bit;

  assign half_m1  = (half_period == '0) ? '0 : half_period - DIV_W'(1);
  assign tick     = (cnt == half_m1);
  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign ext_fall = ~sync_q[1] & sync_q[2];
  assign nxt_bit  = bitn + BIT_W'(1);

  assign frame_end = busy && (bitn == LAST) &&
                     (ext_clk_sel ? ext_rise : (tick && phase_hi));
  assign load      = !empty_q && (!busy || frame_end);

  assign sclk_out   = sclk_q;
  assign sdata      = sdata_q;
  assign empty_flag = empty_q;
  assign end_flag   = end_q;
  assign empty_irq  = empty_q & empty_ie;
  assign end_irq    = end_q & end_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      shift_q  <= '0;
      empty_q  <= 1'b1;
      end_q    <= 1'b1;
      busy     <= 1'b0;
      phase_hi <= 1'b0;
      armed    <= 1'b0;
      sclk_q   <= 1'b1;
      sdata_q  <= 1'b1;
      bitn     <= '0;
      cnt      <= '0;
      sync_q   <= 3'b111;
    end else begin
      sync_q <= {sync_q[1:0], sclk_in};
      if (wr_en) hold_q <= wr_data;

      if (wr_en) begin
        empty_q <= 1'b0;
        end_q   <= 1'b0;
      end else begin
        if (load) empty_q <= 1'b1;
        if (frame_end && !load) end_q <= 1'b1;
      end

      if (load) begin
        shift_q  <= hold_q;
        sdata_q  <= hold_q[0];
        bitn     <= '0;
        busy     <= 1'b1;
        cnt      <= '0;
        phase_hi <= 1'b0;
        armed    <= 1'b0;
        sclk_q   <= ext_clk_sel;
      end else if (frame_end) begin
        busy   <= 1'b0;
        sclk_q <= 1'b1;
      end else if (busy) begin
        if (ext_clk_sel) begin
          sclk_q <= 1'b1;
          if (ext_rise) armed <= 1'b1;
          if (ext_fall && armed) begin
            bitn    <= nxt_bit;
            sdata_q <= shift_q[nxt_bit];
            armed   <= 1'b0;
          end
        end else if (tick) begin
          cnt <= '0;
          if (!phase_hi) begin
            phase_hi <= 1'b1;
            sclk_q   <= 1'b1;
          end else begin
            phase_hi <= 1'b0;
            sclk_q   <= 1'b0;
            bitn     <= nxt_bit;
            sdata_q  <= shift_q[nxt_bit];
          end
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end

  assert_idle_clock_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_q);

  assert_load_sets_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> empty_q);

  assert_end_only_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_q) |-> !busy);

  assert_idle_data_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sdata_q));

  assert_ext_clock_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ext_clk_sel && $past(ext_clk_sel)) |-> sclk_q);

  assert_data_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !ext_clk_sel && $past(!ext_clk_sel) && !$stable(sdata_q))
      |-> $fell(sclk_q));
endmodule

// File: tb/sync_ser_tx_bench.sv
module sync_ser_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       empty_ie = 1'b0, end_ie = 1'b0, ext_clk_sel = 1'b0, sclk_in = 1'b1;
  logic [7:0] half_period = 8'd1;
  logic       sclk_out, sdata, empty_flag, end_flag, empty_irq, end_irq;

  int checks = 0, fails = 0;
  int cyc = 0, rises = 0, falls = 0, rx_n = 0, rx_bits = 0;
  int last_rise = 0, gap_h = 1;
  bit gap_on = 0, gap_first = 1, prev_sclk = 1'b1;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] rx_q [0:63];
  logic [7:0] exp_q [0:63];

  always #5 clk = ~clk;

  sync_ser_tx u_sync_ser_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .empty_ie(empty_ie), .end_ie(end_ie), .ext_clk_sel(ext_clk_sel),
    .sclk_in(sclk_in), .half_period(half_period), .sclk_out(sclk_out),
    .sdata(sdata), .empty_flag(empty_flag), .end_flag(end_flag),
    .empty_irq(empty_irq), .end_irq(end_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_irq(input bit flag, input bit en);
    return int'(flag & en);
  endfunction

  // receiver model: samples sdata on each rising edge of sclk_out
  always begin
    @(posedge clk);
    #1;
    cyc++;
    if (sclk_out && !prev_sclk) begin
      rises++;
      rx_byte = {sdata, rx_byte[7:1]};
      rx_bits++;
      if (rx_bits == 8) begin
        rx_q[rx_n[5:0]] = rx_byte;
        rx_n++;
        rx_bits = 0;
      end
      if (gap_on) begin
        if (!gap_first) check(cyc - last_rise == 2 * gap_h, "R5 rise spacing", cyc - last_rise, 2 * gap_h);
        gap_first = 0;
        last_rise = cyc;
      end
    end
    if (!sclk_out && prev_sclk) falls++;
    prev_sclk = sclk_out;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic write1(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_end();
    @(negedge clk);
    while (!end_flag) @(negedge clk);
  endtask

  task automatic stream_run(input int n, input int h);
    int base;
    logic [7:0] b;
    base = rx_n;
    half_period = 8'(h);
    gap_h = (h == 0) ? 1 : h;
    gap_first = 1;
    gap_on = 1;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      exp_q[6'(base + i)] = b;
      @(negedge clk);
      while (!empty_flag) @(negedge clk);
      if (i > 0) check(end_flag == 1'b0, "R5 no end mid-stream", end_flag, 0);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk); wr_en = 1'b0;
    end
    wait_end();
    gap_on = 0;
    check(rx_n == base + n, "R4 frame count", rx_n, base + n);
    for (int i = 0; i < n; i++)
      check(rx_q[6'(base + i)] == exp_q[6'(base + i)], "R4 byte order",
            rx_q[6'(base + i)], exp_q[6'(base + i)]);
    check(sdata == exp_q[6'(base + n - 1)][7] && sclk_out, "R6 park level",
          {sclk_out, sdata}, {1'b1, exp_q[6'(base + n - 1)][7]});
  endtask

  initial begin
    int r0, f0, base;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(empty_flag && end_flag, "R1 flags after reset", {empty_flag, end_flag}, 3);
    check(sclk_out && sdata, "R1 lines after reset", {sclk_out, sdata}, 3);
    check(!empty_irq && !end_irq, "R1 irq after reset", {empty_irq, end_irq}, 0);

    for (int m = 0; m < 4; m++) begin
      empty_ie = m[0]; end_ie = m[1];
      @(negedge clk);
      check(int'(empty_irq) == exp_irq(empty_flag, empty_ie), "R7 empty_irq", empty_irq, exp_irq(empty_flag, empty_ie));
      check(int'(end_irq) == exp_irq(end_flag, end_ie), "R7 end_irq", end_irq, exp_irq(end_flag, end_ie));
    end

    half_period = 8'd2;
    r0 = rises;
    write1(8'h5A);
    check(!empty_flag && !end_flag, "R2 write clears flags", {empty_flag, end_flag}, 0);
    check(!empty_irq && !end_irq, "R7 irq drop on write", {empty_irq, end_irq}, 0);
    @(negedge clk);
    check(empty_flag && !sclk_out && sdata == 1'b0, "R3 load", {empty_flag, sclk_out, sdata}, 3'b100);
    check(empty_irq, "R7 empty_irq at load", empty_irq, 1);
    wait_end();
    check(rx_q[6'(rx_n - 1)] == 8'h5A, "R4 single byte", rx_q[6'(rx_n - 1)], 8'h5A);
    check(rises - r0 == 8, "R4 eight pulses", rises - r0, 8);
    check(sdata == 1'b0 && sclk_out && end_irq, "R6 park after 5A", {sdata, sclk_out, end_irq}, 3'b011);

    stream_run(6, 1);
    stream_run(6, 3);
    stream_run(5, 0);
    for (int k = 0; k < 3; k++) stream_run(4, 1 + int'($urandom % 4));

    // same-cycle write and load
    half_period = 8'd1;
    base = rx_n;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hC3;
    @(negedge clk); wr_data = 8'h17;
    @(negedge clk); wr_en = 1'b0;
    check(!empty_flag, "R9 write wins over load", empty_flag, 0);
    wait_end();
    check(rx_n == base + 2 && rx_q[6'(base)] == 8'hC3 && rx_q[6'(base + 1)] == 8'h17,
          "R9 both bytes in order", rx_q[6'(base + 1)], 8'h17);

    // write on the frame-close cycle
    base = rx_n;
    r0 = rises;
    write1(8'h81);
    while (rises - r0 < 8) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h6E;
    @(negedge clk); wr_en = 1'b0;
    check(!end_flag && !empty_flag, "R9 write wins over end", {end_flag, empty_flag}, 0);
    wait_end();
    check(rx_n == base + 2 && rx_q[6'(base + 1)] == 8'h6E, "R9 late byte sent", rx_q[6'(base + 1)], 8'h6E);

    // external clock mode
    ext_clk_sel = 1'b1;
    f0 = falls;
    write1(8'h3C);
    repeat (3) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      sclk_in = 1'b0;
      repeat (10) @(negedge clk);
      check(sdata == 1'(8'h3C >> b), "R8 external bit", sdata, int'(1'(8'h3C >> b)));
      sclk_in = 1'b1;
      repeat (10) @(negedge clk);
    end
    check(end_flag && sdata == 1'b0, "R8 external frame end", {end_flag, sdata}, 2);
    check(falls == f0 && sclk_out, "R8 clock output held high", falls - f0, 0);
    ext_clk_sel = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule